// File: doc/BRIEF.md
# Interruption Entry Sequencer

When the pipeline accepts an interruption with a code, this block carries out the entry sequence as a multi-cycle state machine. It keeps the old processor status word and loads a forced replacement. It records the front and back instruction space and offset queues in the interruption registers. If the old status word has its Q bit set, it may fetch the faulting instruction word into the instruction register, and it then copies seven general registers into shadow registers. Last, it points fetch at the vector table entry for the code and raises a one-cycle done pulse.

The block samples the pipeline's state when `start_i` is accepted in IDLE. Other logic provides the general-register read data, the translation lookup and the physical memory read. Every saved control register is held in this block and appears on its outputs.

The state machine has the states IDLE, SAVE, XLAT, MEM_REQ, MEM_WAIT, SHADOW and VECTOR. Its transitions:
- IDLE goes to SAVE on `start_i`.
- SAVE goes to VECTOR when old Q is clear. With Q set it goes to XLAT for a capture code with old C set, to MEM_REQ for a capture code with C clear, and to SHADOW for any other code.
- XLAT goes to MEM_REQ on a successful response and to SHADOW on a failed one.
- MEM_REQ goes to MEM_WAIT when ready is seen.
- MEM_WAIT goes to SHADOW on response valid.
- SHADOW goes to VECTOR after its seventh copy.
- VECTOR returns to IDLE.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, every saved register output, every shadow register and the instruction register are all zero.
- R2: An accepted start stores the `psw_i` value of the start cycle into `ipsw_o`.
- R3: `new_psw_o` is zero except for bit 28, which is set because the wide-mode parameter defaults to 1. Bit 4 (machine check) is also set when the code equals HPMC_CODE, whose default is 1.
- R4: `iiasq_o` and `iiasq_back_o` hold bits 63:32 of the front and back space queue inputs. `iiaoq_o` and `iiaoq_back_o` hold the front and back offset queue inputs.
- R5: With old Q (status bit 3) set, shadow registers 0 to 6 receive general registers 1, 8, 9, 16, 17, 24 and 25, copied in that order. With Q clear, the shadow registers are left unchanged.
- R6: Only codes 12 to 22 and 26 to 28 capture the instruction, and only with Q set. Every other case leaves `iir_o` unchanged and issues no memory read.
- R7: With old C (status bit 18) clear, the capture reads memory at the front offset with bits 1:0 cleared and loads the returned word into `iir_o`.
- R8: With old C set, that aligned address and the front space go to the translation port first. On success the read uses the returned physical address. On failure `iir_o` becomes 0 and no memory read is issued.
- R9: On redirection, `iaoq_f_o` becomes the vector base plus 32 times the code, and `iaoq_b_o` becomes that value plus 4. Both new space queue outputs are 0.
- R10: `done_o` is a one-cycle pulse. `busy_o` is high from the edge that accepts start until `done_o` rises. With Q clear, `done_o` is high right after the third rising edge, counting the edge that samples start as the first.
- R11: A start strobe that arrives while busy is ignored and does not change the sequence in progress.
- R12: The memory request keeps `mem_req_valid_o` high and `mem_addr_o` stable until `mem_req_ready_i` is seen. The translation request stays high until a response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Interruption accepted strobe |
| code_i | input | CODE_W | Interruption code |
| psw_i | input | WORD_W | Current status word |
| iasq_f_i | input | SPACE_W | Front instruction space queue |
| iasq_b_i | input | SPACE_W | Back instruction space queue |
| iaoq_f_i | input | WORD_W | Front instruction offset queue |
| iaoq_b_i | input | WORD_W | Back instruction offset queue |
| iva_i | input | WORD_W | Vector table base |
| gr_raddr_o | output | 5 | General-register read address |
| gr_rdata_i | input | WORD_W | General-register read data, same cycle |
| xlat_req_o | output | 1 | Translation request |
| xlat_space_o | output | SPACE_W | Space for translation |
| xlat_vaddr_o | output | WORD_W | Offset for translation |
| xlat_rsp_valid_i | input | 1 | Translation response valid |
| xlat_ok_i | input | 1 | Translation succeeded |
| xlat_paddr_i | input | WORD_W | Translated physical address |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory read request accepted |
| mem_addr_o | output | WORD_W | Memory read physical address |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rsp_data_i | input | WORD_W | Memory read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Redirection complete pulse |
| ipsw_o | output | WORD_W | Saved status word |
| new_psw_o | output | WORD_W | Forced status word |
| iiasq_o | output | SPACE_W/2 | Saved front space |
| iiasq_back_o | output | SPACE_W/2 | Saved back space |
| iiaoq_o | output | WORD_W | Saved front offset |
| iiaoq_back_o | output | WORD_W | Saved back offset |
| iir_o | output | WORD_W | Captured instruction word |
| shadow_o | output | 7*WORD_W | Shadow registers, shadow k at bits k*WORD_W |
| iaoq_f_o | output | WORD_W | New front offset |
| iaoq_b_o | output | WORD_W | New back offset |
| iasq_f_o | output | SPACE_W | New front space |
| iasq_b_o | output | SPACE_W | New back space |

## Verification
The bench builds the block with its default parameters: 6-bit codes, 32-bit offsets, 64-bit spaces and machine-check code 1. With 6-bit codes the random stimulus can reach all 64 codes. That covers every member and non-member of the capture set and vector offsets up to 63 times 32 above the base. With these widths the space upper halves and the aligned capture address can also be checked bit for bit. Random response delays on the translation and memory ports exercise the held request, and a strobe injected mid-sequence exercises the busy guard.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int SHADOW_N     = 7;
    localparam int SHADOW_IDX_W = 3;
    localparam int GR_ADDR_W    = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_XLAT,
        ST_MEM_REQ,
        ST_MEM_WAIT,
        ST_SHADOW,
        ST_VECTOR
    } seq_state_e;

    // Shadow slot k copies general register 1 for k=0, otherwise 8*((k+1)/2) + ((k+1)%2)
    function automatic logic [GR_ADDR_W-1:0] shadow_gr(input logic [SHADOW_IDX_W-1:0] idx);
        logic [3:0] k1;
        k1 = {1'b0, idx} + 4'd1;
        if (idx == '0) begin
            return 5'd1;
        end
        return {k1[2:1], 3'b000} | {4'b0000, k1[0]};
    endfunction

endpackage

// File: rtl/irq_capture_filter.sv
module irq_capture_filter #(
    parameter int CODE_W = 6,
    parameter logic [(2**CODE_W)-1:0] CAPTURE_MASK = '0
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              capture_o
);

    assign capture_o = CAPTURE_MASK[code_i];

endmodule

// File: rtl/irq_vector_calc.sv
module irq_vector_calc #(
    parameter int          WORD_W    = 32,
    parameter int          CODE_W    = 6,
    parameter int          HPMC_CODE = 1,
    parameter int          W_BIT     = 28,
    parameter int          M_BIT     = 4,
    parameter logic        WIDE_MODE = 1'b1
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [WORD_W-1:0] iva_i,
    output logic [WORD_W-1:0] new_psw_o,
    output logic [WORD_W-1:0] vec_front_o,
    output logic [WORD_W-1:0] vec_back_o
);

    localparam int SLOT_SHIFT = 5;

    always_comb begin
        new_psw_o        = '0;
        new_psw_o[W_BIT] = WIDE_MODE;
        if (code_i == CODE_W'(HPMC_CODE)) begin
            new_psw_o[M_BIT] = 1'b1;
        end
    end

    assign vec_front_o = iva_i + (WORD_W'(code_i) << SLOT_SHIFT);
    assign vec_back_o  = vec_front_o + WORD_W'(4);

endmodule

// File: rtl/irq_shadow_bank.sv
module irq_shadow_bank
    import irq_entry_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [SHADOW_IDX_W-1:0]    wr_idx_i,
    input  logic [WORD_W-1:0]          wr_data_i,
    output logic [SHADOW_N*WORD_W-1:0] shadow_o
);

    logic [WORD_W-1:0] slot_q [SHADOW_N];

    for (genvar g = 0; g < SHADOW_N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == SHADOW_IDX_W'(g))) begin
                slot_q[g] <= wr_data_i;
            end
        end
        assign shadow_o[g*WORD_W +: WORD_W] = slot_q[g];
    end

    AST_SHADOW_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (wr_idx_i < SHADOW_IDX_W'(SHADOW_N))); // R5

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int   WORD_W    = 32,
    parameter int   SPACE_W   = 64,
    parameter int   CODE_W    = 6,
    parameter int   HPMC_CODE = 1,
    parameter int   PSW_W_BIT = 28,
    parameter int   PSW_M_BIT = 4,
    parameter int   PSW_Q_BIT = 3,
    parameter int   PSW_C_BIT = 18,
    parameter logic WIDE_MODE = 1'b1,
    parameter logic [(2**CODE_W)-1:0] CAPTURE_MASK = 64'h0000_0000_1C7F_F000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [CODE_W-1:0]          code_i,
    input  logic [WORD_W-1:0]          psw_i,
    input  logic [SPACE_W-1:0]         iasq_f_i,
    input  logic [SPACE_W-1:0]         iasq_b_i,
    input  logic [WORD_W-1:0]          iaoq_f_i,
    input  logic [WORD_W-1:0]          iaoq_b_i,
    input  logic [WORD_W-1:0]          iva_i,
    output logic [GR_ADDR_W-1:0]       gr_raddr_o,
    input  logic [WORD_W-1:0]          gr_rdata_i,
    output logic                       xlat_req_o,
    output logic [SPACE_W-1:0]         xlat_space_o,
    output logic [WORD_W-1:0]          xlat_vaddr_o,
    input  logic                       xlat_rsp_valid_i,
    input  logic                       xlat_ok_i,
    input  logic [WORD_W-1:0]          xlat_paddr_i,
    output logic                       mem_req_valid_o,
    input  logic                       mem_req_ready_i,
    output logic [WORD_W-1:0]          mem_addr_o,
    input  logic                       mem_rsp_valid_i,
    input  logic [WORD_W-1:0]          mem_rsp_data_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [WORD_W-1:0]          ipsw_o,
    output logic [WORD_W-1:0]          new_psw_o,
    output logic [SPACE_W/2-1:0]       iiasq_o,
    output logic [SPACE_W/2-1:0]       iiasq_back_o,
    output logic [WORD_W-1:0]          iiaoq_o,
    output logic [WORD_W-1:0]          iiaoq_back_o,
    output logic [WORD_W-1:0]          iir_o,
    output logic [SHADOW_N*WORD_W-1:0] shadow_o,
    output logic [WORD_W-1:0]          iaoq_f_o,
    output logic [WORD_W-1:0]          iaoq_b_o,
    output logic [SPACE_W-1:0]         iasq_f_o,
    output logic [SPACE_W-1:0]         iasq_b_o
);

    localparam int SPACE_HI_W = SPACE_W / 2;
    localparam logic [SHADOW_IDX_W-1:0] LAST_IDX = SHADOW_IDX_W'(SHADOW_N - 1);

    seq_state_e state_q, state_d;

    // snapshot taken on an accepted start
    logic [CODE_W-1:0]     code_q;
    logic [WORD_W-1:0]     psw_q;
    logic [SPACE_W-1:0]    iasq_f_q;
    logic [SPACE_HI_W-1:0] iasq_b_hi_q;
    logic [WORD_W-1:0]     iaoq_f_q;
    logic [WORD_W-1:0]     iaoq_b_q;
    logic [WORD_W-1:0]     iva_q;

    logic [WORD_W-1:0]       addr_q;
    logic [SHADOW_IDX_W-1:0] sh_idx_q;
    logic                    unused_space_lo;

    logic              capture;
    logic [WORD_W-1:0] calc_psw;
    logic [WORD_W-1:0] calc_front;
    logic [WORD_W-1:0] calc_back;
    logic              old_q;
    logic              old_c;

    assign unused_space_lo = ^iasq_b_i[SPACE_HI_W-1:0];
    assign old_q = psw_q[PSW_Q_BIT];
    assign old_c = psw_q[PSW_C_BIT];

    irq_capture_filter #(
        .CODE_W       (CODE_W),
        .CAPTURE_MASK (CAPTURE_MASK)
    ) u_filter (
        .code_i    (code_q),
        .capture_o (capture)
    );

    irq_vector_calc #(
        .WORD_W    (WORD_W),
        .CODE_W    (CODE_W),
        .HPMC_CODE (HPMC_CODE),
        .W_BIT     (PSW_W_BIT),
        .M_BIT     (PSW_M_BIT),
        .WIDE_MODE (WIDE_MODE)
    ) u_vector (
        .code_i      (code_q),
        .iva_i       (iva_q),
        .new_psw_o   (calc_psw),
        .vec_front_o (calc_front),
        .vec_back_o  (calc_back)
    );

    irq_shadow_bank #(
        .WORD_W (WORD_W)
    ) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (state_q == ST_SHADOW),
        .wr_idx_i  (sh_idx_q),
        .wr_data_i (gr_rdata_i),
        .shadow_o  (shadow_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_SAVE;
            end
            ST_SAVE: begin
                if (!old_q)          state_d = ST_VECTOR;
                else if (!capture)   state_d = ST_SHADOW;
                else if (old_c)      state_d = ST_XLAT;
                else                 state_d = ST_MEM_REQ;
            end
            ST_XLAT: begin
                if (xlat_rsp_valid_i) state_d = xlat_ok_i ? ST_MEM_REQ : ST_SHADOW;
            end
            ST_MEM_REQ: begin
                if (mem_req_ready_i) state_d = ST_MEM_WAIT;
            end
            ST_MEM_WAIT: begin
                if (mem_rsp_valid_i) state_d = ST_SHADOW;
            end
            ST_SHADOW: begin
                if (sh_idx_q == LAST_IDX) state_d = ST_VECTOR;
            end
            ST_VECTOR: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q       <= '0;
            psw_q        <= '0;
            iasq_f_q     <= '0;
            iasq_b_hi_q  <= '0;
            iaoq_f_q     <= '0;
            iaoq_b_q     <= '0;
            iva_q        <= '0;
            addr_q       <= '0;
            sh_idx_q     <= '0;
            done_o       <= 1'b0;
            ipsw_o       <= '0;
            new_psw_o    <= '0;
            iiasq_o      <= '0;
            iiasq_back_o <= '0;
            iiaoq_o      <= '0;
            iiaoq_back_o <= '0;
            iir_o        <= '0;
            iaoq_f_o     <= '0;
            iaoq_b_o     <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        code_q      <= code_i;
                        psw_q       <= psw_i;
                        iasq_f_q    <= iasq_f_i;
                        iasq_b_hi_q <= iasq_b_i[SPACE_W-1 -: SPACE_HI_W];
                        iaoq_f_q    <= iaoq_f_i;
                        iaoq_b_q    <= iaoq_b_i;
                        iva_q       <= iva_i;
                        sh_idx_q    <= '0;
                    end
                end
                ST_SAVE: begin
                    ipsw_o       <= psw_q;
                    new_psw_o    <= calc_psw;
                    iiasq_o      <= iasq_f_q[SPACE_W-1 -: SPACE_HI_W];
                    iiasq_back_o <= iasq_b_hi_q;
                    iiaoq_o      <= iaoq_f_q;
                    iiaoq_back_o <= iaoq_b_q;
                    addr_q       <= {iaoq_f_q[WORD_W-1:2], 2'b00};
                end
                ST_XLAT: begin
                    if (xlat_rsp_valid_i) begin
                        if (xlat_ok_i) addr_q <= xlat_paddr_i;
                        else           iir_o  <= '0;
                    end
                end
                ST_MEM_REQ: begin
                end
                ST_MEM_WAIT: begin
                    if (mem_rsp_valid_i) iir_o <= mem_rsp_data_i;
                end
                ST_SHADOW: begin
                    sh_idx_q <= sh_idx_q + 1'b1;
                end
                ST_VECTOR: begin
                    iaoq_f_o <= calc_front;
                    iaoq_b_o <= calc_back;
                    done_o   <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    assign busy_o          = (state_q != ST_IDLE);
    assign gr_raddr_o      = shadow_gr(sh_idx_q);
    assign xlat_req_o      = (state_q == ST_XLAT);
    assign xlat_space_o    = iasq_f_q;
    assign xlat_vaddr_o    = addr_q;
    assign mem_req_valid_o = (state_q == ST_MEM_REQ);
    assign mem_addr_o      = addr_q;
    assign iasq_f_o        = '0;
    assign iasq_b_o        = '0;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(code_q) && $stable(psw_q))); // R11
    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o))); // R12
    AST_XLAT_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req_o && !xlat_rsp_valid_i) |=> xlat_req_o); // R12
    AST_MEM_ONLY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> (old_q && capture)); // R6
    AST_XLAT_ONLY_C: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req_o |-> (old_c && old_q && capture)); // R8
    AST_SHADOW_NEEDS_Q: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHADOW) |-> old_q); // R5
    AST_DONE_BACK_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (iaoq_b_o == iaoq_f_o + WORD_W'(4))); // R9

endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        start_i = 0;
    logic [5:0]  code_i = '0;
    logic [31:0] psw_i = '0;
    logic [63:0] iasq_f_i = '0, iasq_b_i = '0;
    logic [31:0] iaoq_f_i = '0, iaoq_b_i = '0, iva_i = '0;
    logic [4:0]  gr_raddr_o;
    logic [31:0] gr_rdata_i;
    logic        xlat_req_o;
    logic [63:0] xlat_space_o;
    logic [31:0] xlat_vaddr_o;
    logic        xlat_rsp_valid_i = 0, xlat_ok_i = 0;
    logic [31:0] xlat_paddr_i = '0;
    logic        mem_req_valid_o, mem_req_ready_i = 0;
    logic [31:0] mem_addr_o;
    logic        mem_rsp_valid_i = 0;
    logic [31:0] mem_rsp_data_i = '0;
    logic        busy_o, done_o;
    logic [31:0] ipsw_o, new_psw_o, iiaoq_o, iiaoq_back_o, iir_o, iaoq_f_o, iaoq_b_o;
    logic [31:0] iiasq_o, iiasq_back_o;
    logic [223:0] shadow_o;
    logic [63:0] iasq_f_o, iasq_b_o;

    irq_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .code_i(code_i), .psw_i(psw_i),
        .iasq_f_i(iasq_f_i), .iasq_b_i(iasq_b_i), .iaoq_f_i(iaoq_f_i), .iaoq_b_i(iaoq_b_i),
        .iva_i(iva_i), .gr_raddr_o(gr_raddr_o), .gr_rdata_i(gr_rdata_i),
        .xlat_req_o(xlat_req_o), .xlat_space_o(xlat_space_o), .xlat_vaddr_o(xlat_vaddr_o),
        .xlat_rsp_valid_i(xlat_rsp_valid_i), .xlat_ok_i(xlat_ok_i), .xlat_paddr_i(xlat_paddr_i),
        .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_addr_o(mem_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
        .busy_o(busy_o), .done_o(done_o), .ipsw_o(ipsw_o), .new_psw_o(new_psw_o),
        .iiasq_o(iiasq_o), .iiasq_back_o(iiasq_back_o), .iiaoq_o(iiaoq_o),
        .iiaoq_back_o(iiaoq_back_o), .iir_o(iir_o), .shadow_o(shadow_o),
        .iaoq_f_o(iaoq_f_o), .iaoq_b_o(iaoq_b_o), .iasq_f_o(iasq_f_o), .iasq_b_o(iasq_b_o)
    );

    int tests = 0;
    int fails = 0;
    logic [31:0] salt = 32'h1357_9BDF;

    // responder bookkeeping
    bit          xlat_ok_cfg = 1'b1;
    int          mem_reads = 0;
    int          xlat_reqs = 0;
    logic [31:0] last_mem_addr = '0;
    logic [31:0] last_xlat_vaddr = '0;
    logic [63:0] last_xlat_space = '0;
    bit          mem_hold_bad = 1'b0;

    // bench models
    function automatic logic [31:0] gr_model(input logic [4:0] a);
        return salt ^ (32'(a) * 32'h0101_0101);
    endfunction

    function automatic logic [31:0] mem_model(input logic [31:0] a);
        return ~a ^ 32'h3C3C_0000;
    endfunction

    function automatic logic [31:0] xlat_model(input logic [31:0] v);
        return v ^ 32'h0040_0000;
    endfunction

    function automatic bit exp_capture(input logic [5:0] c);
        return ((c >= 6'd12) && (c <= 6'd22)) || ((c >= 6'd26) && (c <= 6'd28));
    endfunction

    function automatic logic [31:0] exp_new_psw(input logic [5:0] c);
        logic [31:0] p;
        p = 32'h1000_0000;
        if (c == 6'd1) p = p | 32'h0000_0010;
        return p;
    endfunction

    function automatic logic [4:0] exp_gr(input int k);
        case (k)
            0: return 5'd1;   1: return 5'd8;   2: return 5'd9;
            3: return 5'd16;  4: return 5'd17;  5: return 5'd24;
            default: return 5'd25;
        endcase
    endfunction

    assign gr_rdata_i = gr_model(gr_raddr_o);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // translation and memory responder, driven on falling edges
    initial begin
        int rdy_dly = 0, rsp_dly = 0, x_dly = 0;
        bit pend = 0;
        forever begin
            @(negedge clk);
            mem_req_ready_i  = 0;
            mem_rsp_valid_i  = 0;
            xlat_rsp_valid_i = 0;
            if (pend) begin
                if (rsp_dly == 0) begin
                    mem_rsp_valid_i = 1;
                    mem_rsp_data_i  = mem_model(last_mem_addr);
                    pend = 0;
                end else rsp_dly--;
            end else if (mem_req_valid_o) begin
                if (mem_addr_o != last_mem_addr && rdy_dly > 0 && mem_reads > 0) mem_hold_bad = 1;
                if (rdy_dly == 0) begin
                    mem_req_ready_i = 1;
                    last_mem_addr = mem_addr_o;
                    mem_reads++;
                    pend = 1;
                    rsp_dly = $urandom % 3;
                    rdy_dly = $urandom % 3;
                end else rdy_dly--;
            end
            if (xlat_req_o) begin
                if (x_dly == 0) begin
                    xlat_rsp_valid_i = 1;
                    xlat_ok_i = xlat_ok_cfg;
                    xlat_paddr_i = xlat_model(xlat_vaddr_o);
                    last_xlat_vaddr = xlat_vaddr_o;
                    last_xlat_space = xlat_space_o;
                    xlat_reqs++;
                    x_dly = $urandom % 4;
                end else x_dly--;
            end
        end
    end

    logic [31:0] exp_iir = '0;
    logic [31:0] exp_sh [7];

    task automatic run_case(input logic [5:0] code, input logic [31:0] psw,
                            input logic [63:0] sf, input logic [63:0] sb,
                            input logic [31:0] of, input logic [31:0] ob,
                            input logic [31:0] iva, input bit xok, input bit poke);
        int cycles;
        bit q, c, cap;
        logic [31:0] al;
        @(negedge clk);
        salt = $urandom;
        xlat_ok_cfg = xok;
        mem_reads = 0;
        xlat_reqs = 0;
        code_i = code; psw_i = psw; iasq_f_i = sf; iasq_b_i = sb;
        iaoq_f_i = of; iaoq_b_i = ob; iva_i = iva;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        // inputs change after acceptance: only the snapshot may matter
        psw_i = ~psw; iaoq_f_i = ~of; code_i = ~code;
        cycles = 1;
        check(busy_o == 1'b1, "R10", "busy after start", 64'(busy_o), 64'd1);
        if (poke) start_i = 1;   // R11: strobe while busy
        @(negedge clk);
        start_i = 0;
        cycles++;
        while (!done_o && cycles < 200) begin
            @(negedge clk);
            cycles++;
        end
        q = psw[3];
        c = psw[18];
        cap = exp_capture(code);
        al = {of[31:2], 2'b00};
        if (!done_o) check(1'b0, "R10", "done timeout", 64'(cycles), 64'd0);
        if (!q) check(cycles == 3, "R10", "latency with Q clear", 64'(cycles), 64'd3);
        check(ipsw_o == psw, "R2", "ipsw", 64'(ipsw_o), 64'(psw));
        check(new_psw_o == exp_new_psw(code), "R3", "new psw", 64'(new_psw_o), 64'(exp_new_psw(code)));
        check(iiasq_o == sf[63:32] && iiasq_back_o == sb[63:32], "R4", "space queue",
              {iiasq_o, iiasq_back_o}, {sf[63:32], sb[63:32]});
        check(iiaoq_o == of && iiaoq_back_o == ob, "R4", "offset queue",
              {iiaoq_o, iiaoq_back_o}, {of, ob});
        check(iaoq_f_o == iva + 32'(code) * 32 && iaoq_b_o == iva + 32'(code) * 32 + 4, "R9",
              "vector offsets", {iaoq_f_o, iaoq_b_o}, {iva + 32'(code) * 32, iva + 32'(code) * 32 + 4});
        check(iasq_f_o == 0 && iasq_b_o == 0, "R9", "space cleared", iasq_f_o | iasq_b_o, 64'd0);
        if (q) begin
            for (int k = 0; k < 7; k++) exp_sh[k] = gr_model(exp_gr(k));
            if (cap) begin
                if (c) begin
                    check(xlat_reqs == 1 && last_xlat_vaddr == al && last_xlat_space == sf, "R8",
                          "xlat request", 64'(last_xlat_vaddr), 64'(al));
                    if (xok) begin
                        exp_iir = mem_model(xlat_model(al));
                        check(mem_reads == 1 && last_mem_addr == xlat_model(al), "R8",
                              "translated read addr", 64'(last_mem_addr), 64'(xlat_model(al)));
                    end else begin
                        exp_iir = '0;
                        check(mem_reads == 0, "R8", "no read after failed xlat", 64'(mem_reads), 64'd0);
                    end
                end else begin
                    exp_iir = mem_model(al);
                    check(mem_reads == 1 && last_mem_addr == al && xlat_reqs == 0, "R7",
                          "direct read addr", 64'(last_mem_addr), 64'(al));
                end
            end
        end
        if (!(q && cap)) check(mem_reads == 0 && xlat_reqs == 0, "R6", "no capture traffic",
                               64'(mem_reads), 64'd0);
        check(iir_o == exp_iir, "R6", "instruction reg", 64'(iir_o), 64'(exp_iir));
        for (int k = 0; k < 7; k++)
            check(shadow_o[k*32 +: 32] == exp_sh[k], "R5", "shadow slot",
                  64'(shadow_o[k*32 +: 32]), 64'(exp_sh[k]));
        @(negedge clk);
        check(!done_o && !busy_o, "R10", "done one cycle", {62'd0, done_o, busy_o}, 64'd0);
        if (poke) check(!busy_o, "R11", "no second sequence", 64'(busy_o), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd5318));
        for (int k = 0; k < 7; k++) exp_sh[k] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o, "R1", "reset flags", {62'd0, busy_o, done_o}, 64'd0);
        check(ipsw_o == 0 && new_psw_o == 0 && iir_o == 0 && iaoq_f_o == 0 && iaoq_b_o == 0,
              "R1", "reset regs", 64'(ipsw_o | new_psw_o | iir_o | iaoq_f_o), 64'd0);
        check(shadow_o == '0 && iiaoq_o == 0 && iiasq_o == 0, "R1", "reset shadow", 64'(shadow_o[63:0]), 64'd0);
        rst_n = 1;
        // directed corners
        run_case(6'd4,  32'h0000_0000, 64'hAAAA_1111_0000_0001, 64'hBBBB_2222_0000_0002,
                 32'h0000_1003, 32'h0000_1007, 32'h0010_0000, 1, 0);           // Q clear
        run_case(6'd1,  32'h0000_0008, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321,
                 32'h2000_0000, 32'h2000_0004, 32'h0000_0800, 1, 0);           // HPMC, no capture
        run_case(6'd12, 32'h0000_0008, 64'h5555_0000_0000_0000, 64'h6666_0000_0000_0000,
                 32'h4000_1237, 32'h4000_123B, 32'h0002_0000, 1, 0);           // capture, C clear
        run_case(6'd28, 32'h0004_0008, 64'h7777_0000_1234_0000, 64'h8888_0000_0000_0000,
                 32'h0800_00F2, 32'h0800_00F6, 32'h0003_0000, 1, 0);           // C set, ok
        run_case(6'd15, 32'h0004_0008, 64'h9999_0000_0000_0000, 64'hAAAA_0000_0000_0000,
                 32'h0900_0010, 32'h0900_0014, 32'h0004_0000, 0, 0);           // C set, fail
        run_case(6'd23, 32'h0004_0008, 64'h1, 64'h2, 32'h11, 32'h15, 32'h5000, 1, 0); // just outside set
        run_case(6'd63, 32'hFFFF_FFF7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'hFFFF_FFFF,
                 32'h0, 32'hFFFF_F000, 1, 0);                                  // max code, Q clear
        run_case(6'd20, 32'h0000_0008, 64'h3, 64'h4, 32'h0000_8001, 32'h0000_8005,
                 32'h0000_4000, 1, 1);                                         // R11 poke
        run_case(6'd2,  32'h0000_0000, 64'h5, 64'h6, 32'h20, 32'h24, 32'h100, 1, 1);  // R11 poke, short path
        for (int n = 0; n < 200; n++) begin
            logic [5:0]  cd;
            logic [31:0] p;
            cd = ($urandom % 2 == 0) ? 6'(12 + $urandom % 17) : 6'($urandom);
            p = $urandom;
            run_case(cd, p, {$urandom, $urandom}, {$urandom, $urandom}, $urandom, $urandom,
                     $urandom, bit'($urandom % 2), bit'($urandom % 5 == 0));
        end
        check(!mem_hold_bad, "R12", "request held stable", 64'(mem_hold_bad), 64'd0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule